// File: doc/BRIEF.md
# Microwire serial master controller

This block is a register-programmed serial master for Microwire-style peripherals. Software reaches it through a small 16-bit register bus. It first configures a global clock prescale and a setup field for each of four chip selects. Each setup field holds the sampling edge, the launch edge, the select polarity and the rate. Software then selects a device with an explicit chip-select command. Finally it writes a single command word that holds a write bit count, a read bit count and a start bit.

A transfer shifts the write bits out of the top of the data register, MSB first. The read bits follow with no pause, also MSB first, and are gathered into the low end of the same register. The serial clock runs only while a transfer is in progress and idles low otherwise. A busy flag covers both chip-select commands and transfers. A ready flag shows that received data is waiting, and reading the data register clears it.

Top module: `mwire_master`

## Requirements
- R1: After reset the busy flag (control bit 14) and the ready flag (control bit 15) are 0. The data register reads 0, and sclk and sdo are 0. Every chip-select line is inactive, which is high, because the reset polarity field is 0.
- R2: The setup registers at 0x04 and 0x06 read back their low 12 written bits. The global clock register at 0x08 reads back its low 3 written bits, and it reads 0 after reset.
- R3: Writing the control register at 0x02 with bit 13 clear is a chip-select command. Bits [11:10] give the index. Bit 12 set asserts that select, and bit 12 clear releases it. The busy flag is high for exactly the one cycle after the write. Select n takes its 6-bit field from 0x04 (n = 0, 1) or 0x06 (n = 2, 3), at bit offset 6 for odd n. An asserted line drives field bit 2, and an inactive line drives its inverse.
- R4: Writing the control register with bit 13 set starts a transfer. The transfer has bits [9:5] write bits, then bits [4:0] read bits, each 0 to 16, for exactly write+read sclk pulses. The write bits are data-register bits [15:16-N], sent MSB first.
- R5: When field bit 1 is 0, sdo changes at sclk rising edges and is stable at falling edges. When it is 1, the first bit is present from the start and sdo changes at falling edges, so it is stable at rising edges.
- R6: When field bit 0 is 0, sdi is sampled at rising edges, and when it is 1, at falling edges. After a transfer with a read phase, the data register holds the received bits right-aligned, MSB first in time, with zeros above them. The ready flag rises in the cycle that busy falls.
- R7: Reading the data register at 0x00 clears the ready flag, and so does starting a transfer.
- R8: One sclk period is P*D system clocks. P comes from 0x08 bits [2:1] with codes 0,1,2,3 giving 2,4,7,10. D comes from field bits [4:3] with codes 0,1,2,3 giving 2,4,8,8. sclk is low whenever the block is not busy.
- R9: While 0x08 bit 0 is 0, a started transfer produces no sclk edge and stays busy. Setting the bit lets the transfer resume and complete.
- R10: A control write made while busy is ignored, whether it is a start or a chip-select command. The selects keep their state and the running transfer keeps its bit count.
- R11: A start with both counts zero produces no sclk edge, clears busy, and leaves the ready flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the peripheral |
| sdi | input | 1 | Serial data from the peripheral |
| cs_out | output | 4 | Chip-select lines, per-device polarity |

## Verification
Transfers are run with these count mixes: write only, read only, a mixed split, both phases at full length, and both counts zero. Non-palindromic words are used, so a reversed bit order or a lost first or last bit shows up. Each launch-edge and sampling-edge combination is captured by a peripheral model that samples on the opposite edge. A wrong-edge implementation therefore corrupts the captured word, not just its timing. Periods are measured for two prescale and rate pairs, including the non-power-of-two prescale, which separates a swapped or off-by-one divider. The gated clock, commands written while busy, and select polarity are each checked at the pins.

// File: rtl/mw_pkg.sv
package mw_pkg;

    parameter int DW      = 16;
    parameter int CNTW    = 5;
    parameter int NCS     = 4;
    parameter int IDXW    = 2;
    parameter int FLDW    = 6;
    parameter int SETW    = 2 * FLDW;
    parameter int GCW     = 3;
    parameter int MAXBITS = 16;
    parameter int BITW    = CNTW + 1;
    parameter int PCW     = 4;
    parameter int RCW     = 2;

    localparam logic [3:0] A_DATA = 4'h0;
    localparam logic [3:0] A_CTRL = 4'h2;
    localparam logic [3:0] A_SET1 = 4'h4;
    localparam logic [3:0] A_SET2 = 4'h6;
    localparam logic [3:0] A_GCLK = 4'h8;

    localparam int C_WR_LO  = 5;
    localparam int C_IDX_LO = 10;
    localparam int C_CMD    = 12;
    localparam int C_START  = 13;
    localparam int C_BUSY   = 14;
    localparam int C_RDY    = 15;

    typedef struct packed {
        logic [1:0] rate;
        logic       cs_lvl;
        logic       launch_fall;
        logic       sample_fall;
    } dev_cfg_t;

    function automatic dev_cfg_t field_of(input logic [SETW-1:0] s1,
                                          input logic [SETW-1:0] s2,
                                          input logic [IDXW-1:0] idx);
        logic [SETW-1:0] r;
        logic [FLDW-1:0] f;
        r = idx[1] ? s2 : s1;
        f = idx[0] ? r[SETW-1:FLDW] : r[FLDW-1:0];
        return dev_cfg_t'(f[4:0]);
    endfunction

    function automatic logic [PCW-1:0] prescale_last(input logic [1:0] code);
        case (code)
            2'd0:    return PCW'(1);
            2'd1:    return PCW'(3);
            2'd2:    return PCW'(6);
            default: return PCW'(9);
        endcase
    endfunction

    function automatic logic [RCW-1:0] rate_half_last(input logic [1:0] code);
        case (code)
            2'd0:    return RCW'(0);
            2'd1:    return RCW'(1);
            default: return RCW'(3);
        endcase
    endfunction

    function automatic logic [CNTW-1:0] clamp_cnt(input logic [CNTW-1:0] n);
        return (n > CNTW'(MAXBITS)) ? CNTW'(MAXBITS) : n;
    endfunction

endpackage

// File: rtl/mw_clkgen.sv
module mw_clkgen
    import mw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       run,
    input  logic [1:0] pre_code,
    input  logic [1:0] rate_code,
    output logic       half_tick
);
    logic [PCW-1:0] pc_q;
    logic [RCW-1:0] rc_q;
    logic           pre_tick;

    assign pre_tick  = run && (pc_q == prescale_last(pre_code));
    assign half_tick = pre_tick && (rc_q == rate_half_last(rate_code));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pc_q <= '0;
            rc_q <= '0;
        end else if (pre_tick) begin
            pc_q <= '0;
            rc_q <= half_tick ? '0 : rc_q + RCW'(1);
        end else if (run) begin
            pc_q <= pc_q + PCW'(1);
        end
    end
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
    import mw_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [CNTW-1:0] wr_n,
    input  logic [CNTW-1:0] rd_n,
    input  logic [DW-1:0]   wdata,
    input  logic            launch_fall,
    input  logic            sample_fall,
    input  logic            half_tick,
    input  logic            sdi,
    output logic            sclk,
    output logic            sdo,
    output logic            busy,
    output logic            fin,
    output logic [DW-1:0]   rx
);
    logic            act_q, fin_q, sclk_q, sdo_q;
    logic [BITW-1:0] bitn_q, tot_q, wrn_q;
    logic [DW-1:0]   wsh_q, rsh_q;
    logic [DW-1:0]   rsh_nx;
    logic            in_wr, last;

    assign rsh_nx = {rsh_q[DW-2:0], sdi};
    assign in_wr  = bitn_q < wrn_q;
    assign last   = bitn_q == (tot_q - BITW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            fin_q  <= 1'b0;
            sclk_q <= 1'b0;
            sdo_q  <= 1'b0;
            bitn_q <= '0;
            tot_q  <= '0;
            wrn_q  <= '0;
            wsh_q  <= '0;
            rsh_q  <= '0;
        end else begin
            fin_q <= 1'b0;
            if (start) begin
                act_q  <= 1'b1;
                sclk_q <= 1'b0;
                bitn_q <= '0;
                tot_q  <= BITW'(wr_n) + BITW'(rd_n);
                wrn_q  <= BITW'(wr_n);
                rsh_q  <= '0;
                if (launch_fall && wr_n != '0) begin
                    sdo_q <= wdata[DW-1];
                    wsh_q <= {wdata[DW-2:0], 1'b0};
                end else begin
                    sdo_q <= 1'b0;
                    wsh_q <= wdata;
                end
            end else if (act_q) begin
                if (tot_q == '0) begin
                    act_q <= 1'b0;
                    fin_q <= 1'b1;
                end else if (half_tick) begin
                    if (!sclk_q) begin
                        sclk_q <= 1'b1;
                        if (in_wr && !launch_fall) begin
                            sdo_q <= wsh_q[DW-1];
                            wsh_q <= {wsh_q[DW-2:0], 1'b0};
                        end
                        if (!in_wr && !sample_fall)
                            rsh_q <= rsh_nx;
                    end else begin
                        sclk_q <= 1'b0;
                        if (in_wr && launch_fall && (bitn_q + BITW'(1) < wrn_q)) begin
                            sdo_q <= wsh_q[DW-1];
                            wsh_q <= {wsh_q[DW-2:0], 1'b0};
                        end
                        if (!in_wr && sample_fall)
                            rsh_q <= rsh_nx;
                        bitn_q <= bitn_q + BITW'(1);
                        if (last) begin
                            act_q <= 1'b0;
                            fin_q <= 1'b1;
                            sdo_q <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    assign sclk = sclk_q;
    assign sdo  = sdo_q;
    assign busy = act_q | fin_q;
    assign fin  = fin_q;
    assign rx   = rsh_q;
endmodule

// File: rtl/mwire_master.sv
module mwire_master
    import mw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [3:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          sclk,
    output logic          sdo,
    input  logic          sdi,
    output logic [NCS-1:0] cs_out
);
    logic [DW-1:0]   dreg_q;
    logic [CNTW-1:0] rd_q, wr_q;
    logic [IDXW-1:0] idx_q;
    logic [SETW-1:0] s1_q, s2_q;
    logic [GCW-1:0]  g_q;
    logic [NCS-1:0]  cs_act_q;
    logic            cs_busy_q, rdy_q;

    logic            xbusy, fin, half_tick, busy;
    logic [DW-1:0]   rx;
    logic            wr_acc, ctrl_wr, accept, go, data_rd;
    logic [IDXW-1:0] w_idx, eff_idx;
    logic [CNTW-1:0] w_wr, w_rd;
    dev_cfg_t        cfg;

    assign busy    = cs_busy_q | xbusy;
    assign wr_acc  = bus_sel & bus_we;
    assign ctrl_wr = wr_acc & (bus_addr == A_CTRL);
    assign accept  = ctrl_wr & ~busy;
    assign go      = accept & bus_wdata[C_START];
    assign data_rd = bus_sel & ~bus_we & (bus_addr == A_DATA);
    assign w_idx   = bus_wdata[C_IDX_LO +: IDXW];
    assign w_wr    = clamp_cnt(bus_wdata[C_WR_LO +: CNTW]);
    assign w_rd    = clamp_cnt(bus_wdata[0 +: CNTW]);
    assign eff_idx = go ? w_idx : idx_q;
    assign cfg     = field_of(s1_q, s2_q, eff_idx);

    mw_clkgen u_clk (
        .clk       (clk),
        .rst       (rst),
        .restart   (go),
        .run       (xbusy & g_q[0]),
        .pre_code  (g_q[2:1]),
        .rate_code (cfg.rate),
        .half_tick (half_tick)
    );

    mw_shifter u_shf (
        .clk         (clk),
        .rst         (rst),
        .start       (go),
        .wr_n        (w_wr),
        .rd_n        (w_rd),
        .wdata       (dreg_q),
        .launch_fall (cfg.launch_fall),
        .sample_fall (cfg.sample_fall),
        .half_tick   (half_tick),
        .sdi         (sdi),
        .sclk        (sclk),
        .sdo         (sdo),
        .busy        (xbusy),
        .fin         (fin),
        .rx          (rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dreg_q    <= '0;
            rd_q      <= '0;
            wr_q      <= '0;
            idx_q     <= '0;
            s1_q      <= '0;
            s2_q      <= '0;
            g_q       <= '0;
            cs_act_q  <= '0;
            cs_busy_q <= 1'b0;
            rdy_q     <= 1'b0;
        end else begin
            cs_busy_q <= 1'b0;
            if (wr_acc) begin
                case (bus_addr)
                    A_DATA:  dreg_q <= bus_wdata;
                    A_SET1:  s1_q   <= bus_wdata[SETW-1:0];
                    A_SET2:  s2_q   <= bus_wdata[SETW-1:0];
                    A_GCLK:  g_q    <= bus_wdata[GCW-1:0];
                    default: ;
                endcase
            end
            if (accept) begin
                rd_q  <= w_rd;
                wr_q  <= w_wr;
                idx_q <= w_idx;
                if (bus_wdata[C_START]) begin
                    rdy_q <= 1'b0;
                end else begin
                    cs_act_q[w_idx] <= bus_wdata[C_CMD];
                    cs_busy_q       <= 1'b1;
                end
            end
            if (data_rd)
                rdy_q <= 1'b0;
            if (fin && rd_q != '0) begin
                dreg_q <= rx;
                rdy_q  <= 1'b1;
            end
        end
    end

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        dev_cfg_t ci;
        assign ci        = field_of(s1_q, s2_q, IDXW'(i));
        assign cs_out[i] = cs_act_q[i] ? ci.cs_lvl : ~ci.cs_lvl;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA: bus_rdata = dreg_q;
            A_CTRL: bus_rdata = {rdy_q, busy, 1'b0, cs_act_q[idx_q], idx_q, wr_q, rd_q};
            A_SET1: bus_rdata = {{(DW-SETW){1'b0}}, s1_q};
            A_SET2: bus_rdata = {{(DW-SETW){1'b0}}, s2_q};
            A_GCLK: bus_rdata = {{(DW-GCW){1'b0}}, g_q};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mwire_chk.sv
module mwire_chk
    import mw_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           sclk,
    input logic           rdy,
    input logic           cs_busy,
    input logic           gen,
    input logic [NCS-1:0] cs_act
);
    // R8
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk);

    // R8
    sclk_owned_chk: assert property (@(posedge clk) disable iff (rst) !$stable(sclk) |-> $past(busy));

    // R3
    cs_busy_pulse_chk: assert property (@(posedge clk) disable iff (rst) cs_busy |=> !cs_busy);

    // R6
    rdy_at_end_chk: assert property (@(posedge clk) disable iff (rst) $rose(rdy) |-> $fell(busy));

    // R10
    cs_hold_chk: assert property (@(posedge clk) disable iff (rst) $past(busy) |-> $stable(cs_act));

    // R9
    halt_chk: assert property (@(posedge clk) disable iff (rst) !gen |=> $stable(sclk));
endmodule

bind mwire_master mwire_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .sclk    (sclk),
    .rdy     (rdy_q),
    .cs_busy (cs_busy_q),
    .gen     (g_q[0]),
    .cs_act  (cs_act_q)
);

// File: tb/sim_mwire_master.sv
`timescale 1ns/1ps
module sim_mwire_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sclk, sdo;
    logic        sdi = 1'b0;
    logic [3:0]  cs_out;

    int checks = 0, errors = 0;
    int cyc = 0;
    bit done = 0;

    // transfer context read by the peripheral model
    int          xfer_id = 0;
    int          t_wr = 0, t_rd = 0;
    bit          t_lf = 0, t_sf = 0;
    logic [15:0] t_pat = '0;

    // peripheral model state
    int          seen_id = 0;
    int          rises = 0, falls = 0, per = 0, last_rise = 0;
    logic [15:0] cap = '0;
    logic        sclk_p = 1'b0, sdo_p = 1'b0;

    mwire_master u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs_out(cs_out)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        int idx, b;
        if (xfer_id != seen_id) begin
            seen_id = xfer_id;
            rises = 0; falls = 0; per = 0; cap = '0;
        end
        if (sclk && !sclk_p) begin
            if (t_lf && rises < t_wr) cap = {cap[14:0], sdo_p};
            if (rises > 0) per = cyc - last_rise;
            last_rise = cyc;
            rises++;
        end
        if (!sclk && sclk_p) begin
            if (!t_lf && falls < t_wr) cap = {cap[14:0], sdo_p};
            falls++;
        end
        idx = t_sf ? rises - 1 : falls;
        b = idx - t_wr;
        sdi = (b >= 0 && b < t_rd) ? t_pat[t_rd-1-b] : 1'b0;
        sclk_p = sclk;
        sdo_p = sdo;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic bwrite(logic [3:0] a, logic [15:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bread(logic [3:0] a, output logic [15:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 20000; i++) begin
            bread(4'h2, v);
            if (!v[14]) break;
        end
    endtask

    task automatic start_x(int wr, int rd, logic [15:0] wv, logic [15:0] pat, bit lf, bit sf);
        logic [31:0] al;
        t_wr = wr; t_rd = rd; t_lf = lf; t_sf = sf; t_pat = pat;
        xfer_id++;
        al = {16'h0, wv} << (16 - wr);
        bwrite(4'h0, al[15:0]);
        bwrite(4'h2, 16'h2000 | 16'(wr << 5) | 16'(rd));
    endtask

    task automatic run_xfer(string tag, int wr, int rd, logic [15:0] wv, logic [15:0] pat,
                            bit lf, bit sf, int exp_per);
        logic [15:0] v;
        logic [15:0] wm, rm;
        wm = 16'((32'h1 << wr) - 1);
        rm = 16'((32'h1 << rd) - 1);
        bwrite(4'h4, {13'h0, 1'b0, lf, sf} | 16'h0000);
        start_x(wr, rd, wv, pat, lf, sf);
        wait_idle();
        chk({"R4 pulse count ", tag}, rises, wr + rd);
        chk({"R5 write word ", tag}, cap & wm, wv & wm);
        if (exp_per > 0) chk({"R8 period ", tag}, per, exp_per);
        chk({"R8 sclk idle ", tag}, sclk, 0);
        bread(4'h2, v);
        chk({"R6 ready flag ", tag}, v[15], rd > 0);
        if (rd > 0) begin
            bread(4'h0, v);
            chk({"R6 read word ", tag}, v, pat & rm);
            bread(4'h2, v);
            chk({"R7 ready cleared ", tag}, v[15], 0);
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        bread(4'h2, v);
        chk("R1 ctrl/status", v, 0);
        bread(4'h0, v);
        chk("R1 data", v, 0);
        chk("R1 pins", {sclk, sdo, cs_out}, 6'b001111);
        bread(4'h8, v);
        chk("R2 gclk reset", v, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        bwrite(4'h4, 16'hFABC);
        bread(4'h4, v);
        chk("R2 setup1", v, 16'h0ABC);
        bwrite(4'h8, 16'hFFFD);
        bread(4'h8, v);
        chk("R2 gclk", v, 16'h0005);
        bwrite(4'h4, 16'h0000);
        bwrite(4'h8, 16'h0001);
    endtask

    task automatic t_cs();
        logic [15:0] v;
        bwrite(4'h6, 16'h0004);
        chk("R3 cs2 inactive high-level", cs_out, 4'b1011);
        bwrite(4'h2, 16'h1000);
        bread(4'h2, v);
        chk("R3 busy during cs cmd", v[14], 1);
        bread(4'h2, v);
        chk("R3 busy after cs cmd", v[14], 0);
        chk("R3 cs0 asserted low", cs_out, 4'b1010);
        bwrite(4'h2, 16'h1800);
        wait_idle();
        chk("R3 cs2 asserted high", cs_out, 4'b1110);
        bwrite(4'h2, 16'h0000);
        wait_idle();
        chk("R3 cs0 released", cs_out, 4'b1111);
        bwrite(4'h2, 16'h0800);
        wait_idle();
        bwrite(4'h6, 16'h0000);
        chk("R3 all inactive", cs_out, 4'b1111);
    endtask

    task automatic t_rates();
        bwrite(4'h8, 16'h0005);
        bwrite(4'h4, 16'h0008);
        t_wr = 6; t_rd = 0; t_lf = 0; t_sf = 0; t_pat = 0;
        start_x(6, 0, 16'h002D, 16'h0, 0, 0);
        wait_idle();
        chk("R8 period P7 D4", per, 28);
        chk("R4 pulses P7 D4", rises, 6);
        bwrite(4'h8, 16'h0001);
        bwrite(4'h4, 16'h0010);
        start_x(3, 2, 16'h0005, 16'h0002, 0, 0);
        wait_idle();
        chk("R8 period P2 D8", per, 16);
        bwrite(4'h4, 16'h0000);
    endtask

    task automatic t_halt();
        logic [15:0] v;
        bwrite(4'h8, 16'h0000);
        start_x(4, 0, 16'h0009, 16'h0, 0, 0);
        repeat (100) @(negedge clk);
        chk("R9 no edges while disabled", rises, 0);
        bread(4'h2, v);
        chk("R9 busy while disabled", v[14], 1);
        bwrite(4'h8, 16'h0001);
        wait_idle();
        chk("R9 resumed count", rises, 4);
        chk("R9 resumed word", cap & 16'hF, 16'h9);
    endtask

    task automatic t_ignore();
        bwrite(4'h2, 16'h1000);
        wait_idle();
        bwrite(4'h8, 16'h0007);
        bwrite(4'h4, 16'h0010);
        start_x(16, 0, 16'hA5C3, 16'h0, 0, 0);
        repeat (50) @(negedge clk);
        bwrite(4'h2, 16'h0000);
        bwrite(4'h2, 16'h2021);
        wait_idle();
        chk("R10 cs kept asserted", cs_out[0], 0);
        chk("R10 bit count kept", rises, 16);
        chk("R10 word intact", cap, 16'hA5C3);
        bwrite(4'h2, 16'h0000);
        wait_idle();
        chk("R10 cs released after", cs_out[0], 1);
        bwrite(4'h8, 16'h0001);
        bwrite(4'h4, 16'h0000);
    endtask

    task automatic t_zero();
        logic [15:0] v;
        start_x(0, 0, 16'h0, 16'h0, 0, 0);
        wait_idle();
        chk("R11 no edges", rises, 0);
        bread(4'h2, v);
        chk("R11 idle, no ready", v[15:14], 2'b00);
    endtask

    initial begin
        #750000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_sim();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_regs();
        t_cs();
        run_xfer("w8 rise", 8, 0, 16'h00B4, 16'h0, 0, 0, 4);
        run_xfer("w5r11 lf", 5, 11, 16'h0013, 16'h05A6, 1, 0, 4);
        run_xfer("r16 sf", 0, 16, 16'h0, 16'hC35A, 0, 1, 4);
        run_xfer("w16r16 both", 16, 16, 16'h8E71, 16'h1F2D, 1, 1, 4);
        run_xfer("w1r1", 1, 1, 16'h0001, 16'h0001, 0, 0, 4);
        t_rates();
        t_halt();
        t_ignore();
        t_zero();
        finish_sim();
    end
endmodule